// File: doc/BRIEF.md
# Narrow Memory Lane Sequencer

This block connects a processor that reads through a 32-bit data bus to a memory that may be 8, 16 or 32 bits wide. For each word read it runs the required number of narrow memory cycles: one for word-wide memory, two for halfword-wide memory and four for byte-wide memory. In every cycle it places the narrow read data on the byte lanes that cycle fills and raises the per-lane latch enables for those lanes. The processor's own byte latches build the word, so the bridge keeps no staging register.

An active-low wait output stretches the processor clock. It stays low until the memory reports ready in the final narrow cycle. A per-cycle ready input lets each narrow cycle take any number of wait states. Stores pass in a single cycle with all four lane enables high. The bridge also forms the narrow memory address by appending the lane-group index to the word address.

Top module: `nmls_top`

## Requirements
- R1: While reset is high and after it, with no access in progress, `wait_n` is 1 and `lane_en` is 4'hF.
- R2: With `width_sel` = 2 (word), a read takes one narrow cycle. `lane_en` is 4'hF and `cpu_data` equals `mem_rdata`.
- R3: With `width_sel` = 1 (halfword), a read takes two narrow cycles. `lane_en` is 4'h3 and then 4'hC, and `mem_rdata[15:0]` appears on `cpu_data[15:0]` and then on `cpu_data[31:16]`.
- R4: With `width_sel` = 0 (byte), a read takes four narrow cycles with `lane_en` 4'h1, 4'h2, 4'h4, 4'h8 in that order. In cycle g, `mem_rdata[7:0]` appears on `cpu_data[8g+7:8g]`.
- R5: During an access, `wait_n` is 0 in every cycle except the final narrow cycle in which `mem_rdy` is 1. In that cycle it is 1.
- R6: While `mem_rdy` is 0 during an access, `lane_en` and `mem_addr` hold, `wait_n` stays 0 and the sequence does not advance.
- R7: `mem_addr` is {word address, group[1:0]} for byte memory, {1'b0, word address, group[0]} for halfword memory and {2'b00, word address} for word memory.
- R8: A store (`wr` = 1 with `req`) completes in one narrow cycle at group 0 with `lane_en` = 4'hF, whatever the width.
- R9: `req`, `wr`, `width_sel` and `word_addr` are ignored while an access is in progress. Width and address are taken only when `req` is accepted.
- R10: `width_sel` code 3 behaves as word width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| width_sel | input | 2 | Memory width: 0 byte, 1 halfword, 2 or 3 word |
| req | input | 1 | Start an access (taken when idle) |
| wr | input | 1 | Access is a store |
| word_addr | input | AW | Word address of the access |
| mem_rdy | input | 1 | Memory ready for the current narrow cycle |
| mem_rdata | input | 32 | Narrow read data, right-aligned |
| mem_addr | output | AW+2 | Narrow memory address |
| cpu_data | output | 32 | Steered processor data bus |
| lane_en | output | 4 | Per-byte-lane latch enables, bit i for bits 8i+7:8i |
| wait_n | output | 1 | Active-low processor clock stretch |

## Verification
The hardest case to reach from the ports is a stall in the middle of a sequence. In that case `mem_rdy` drops inside a byte or halfword access after earlier groups have already completed, and at the same time new requests with a different width and address arrive and must not disturb the access in progress. The directed scenarios hold `mem_rdy` low for several cycles within each lane group. One scenario raises `req` with a conflicting width and address in the middle of an access and checks that the enable pattern, the address and the cycle count still follow the width captured at the start.

// File: rtl/nmls_pkg.sv
package nmls_pkg;

  typedef enum logic [1:0] {
    MW_BYTE = 2'd0,
    MW_HALF = 2'd1,
    MW_WORD = 2'd2
  } mw_e;

  // Unused code 3 maps to word width.
  function automatic mw_e norm_width(input logic [1:0] code);
    case (code)
      2'd0:    return MW_BYTE;
      2'd1:    return MW_HALF;
      default: return MW_WORD;
    endcase
  endfunction

  // Index of the final lane group for a width.
  function automatic logic [1:0] final_grp(input mw_e w);
    case (w)
      MW_BYTE: return 2'd3;
      MW_HALF: return 2'd1;
      default: return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/nmls_seq_ctrl.sv
module nmls_seq_ctrl
  import nmls_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          wr,
  input  logic [1:0]    width_sel,
  input  logic [AW-1:0] word_addr,
  input  logic          mem_rdy,
  output logic          busy,
  output logic [1:0]    grp,
  output mw_e           cfg_w,
  output logic          cfg_wr,
  output logic [AW-1:0] addr_q,
  output logic          last
);

  assign last = cfg_wr || (grp == final_grp(cfg_w));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      grp    <= 2'd0;
      cfg_w  <= MW_WORD;
      cfg_wr <= 1'b0;
      addr_q <= '0;
    end else if (!busy) begin
      if (req) begin
        busy   <= 1'b1;
        grp    <= 2'd0;
        cfg_w  <= norm_width(width_sel);
        cfg_wr <= wr;
        addr_q <= word_addr;
      end
    end else if (mem_rdy) begin
      if (last) busy <= 1'b0;
      else      grp  <= grp + 2'd1;
    end
  end

  // R4
  grp_range_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> grp <= final_grp(cfg_w));

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !(last && mem_rdy)) |=> ($stable(cfg_w) && $stable(addr_q) && $stable(cfg_wr)));

endmodule

// File: rtl/nmls_lane_map.sv
module nmls_lane_map
  import nmls_pkg::*;
#(
  parameter int AW     = 10,
  parameter int LANE_W = 8
) (
  input  logic              busy,
  input  logic [1:0]        grp,
  input  mw_e               cfg_w,
  input  logic              cfg_wr,
  input  logic [AW-1:0]     addr_q,
  input  logic [4*LANE_W-1:0] mem_rdata,
  output logic [3:0]        lane_en,
  output logic [AW+1:0]     mem_addr,
  output logic [4*LANE_W-1:0] cpu_data
);

  always_comb begin
    if (!busy || cfg_wr) begin
      lane_en = 4'hF;
    end else begin
      case (cfg_w)
        MW_BYTE: lane_en = 4'b0001 << grp;
        MW_HALF: lane_en = grp[0] ? 4'hC : 4'h3;
        default: lane_en = 4'hF;
      endcase
    end
  end

  always_comb begin
    case (cfg_w)
      MW_BYTE: mem_addr = {addr_q, grp};
      MW_HALF: mem_addr = {1'b0, addr_q, grp[0]};
      default: mem_addr = {2'b00, addr_q};
    endcase
  end

  // Each lane receives the narrow byte that would belong there.
  for (genvar i = 0; i < 4; i++) begin : g_lane
    always_comb begin
      case (cfg_w)
        MW_BYTE: cpu_data[i*LANE_W +: LANE_W] = mem_rdata[0 +: LANE_W];
        MW_HALF: cpu_data[i*LANE_W +: LANE_W] = mem_rdata[(i%2)*LANE_W +: LANE_W];
        default: cpu_data[i*LANE_W +: LANE_W] = mem_rdata[i*LANE_W +: LANE_W];
      endcase
    end
  end

endmodule

// File: rtl/nmls_top.sv
module nmls_top
  import nmls_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    width_sel,
  input  logic          req,
  input  logic          wr,
  input  logic [AW-1:0] word_addr,
  input  logic          mem_rdy,
  input  logic [31:0]   mem_rdata,
  output logic [AW+1:0] mem_addr,
  output logic [31:0]   cpu_data,
  output logic [3:0]    lane_en,
  output logic          wait_n
);

  logic          busy;
  logic [1:0]    grp;
  mw_e           cfg_w;
  logic          cfg_wr;
  logic [AW-1:0] addr_q;
  logic          last;

  nmls_seq_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rst(rst), .req(req), .wr(wr), .width_sel(width_sel),
    .word_addr(word_addr), .mem_rdy(mem_rdy), .busy(busy), .grp(grp),
    .cfg_w(cfg_w), .cfg_wr(cfg_wr), .addr_q(addr_q), .last(last)
  );

  nmls_lane_map #(.AW(AW), .LANE_W(8)) u_map (
    .busy(busy), .grp(grp), .cfg_w(cfg_w), .cfg_wr(cfg_wr), .addr_q(addr_q),
    .mem_rdata(mem_rdata), .lane_en(lane_en), .mem_addr(mem_addr),
    .cpu_data(cpu_data)
  );

  // Stretch until the final group is reported ready.
  assign wait_n = !(busy && !(last && mem_rdy));

  // R1
  idle_wait_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (wait_n && lane_en == 4'hF));

  // R5
  wait_low_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !mem_rdy) |-> !wait_n);

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !mem_rdy) |=> ($stable(lane_en) && $stable(mem_addr)));

  // R4
  byte_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !cfg_wr && cfg_w == MW_BYTE) |-> $countones(lane_en) == 1);

  // R8
  store_lanes_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && cfg_wr) |-> (lane_en == 4'hF && last));

endmodule

// File: tb/nmls_top_test.sv
module nmls_top_test;
  localparam int AW = 10;
  localparam time PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    width_sel = 2'd2;
  logic          req = 1'b0;
  logic          wr = 1'b0;
  logic [AW-1:0] word_addr = '0;
  logic          mem_rdy = 1'b0;
  logic [31:0]   mem_rdata = '0;
  logic [AW+1:0] mem_addr;
  logic [31:0]   cpu_data;
  logic [3:0]    lane_en;
  logic          wait_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  nmls_top #(.AW(AW)) uut (
    .clk(clk), .rst(rst), .width_sel(width_sel), .req(req), .wr(wr),
    .word_addr(word_addr), .mem_rdy(mem_rdy), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .cpu_data(cpu_data), .lane_en(lane_en), .wait_n(wait_n)
  );

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic int n_groups(input logic [1:0] w);
    return (w == 2'd0) ? 4 : (w == 2'd1) ? 2 : 1;
  endfunction

  function automatic logic [3:0] exp_en(input logic [1:0] w, input int g);
    if (w == 2'd0) return 4'b0001 << g;
    if (w == 2'd1) return (g == 0) ? 4'h3 : 4'hC;
    return 4'hF;
  endfunction

  function automatic logic [AW+1:0] exp_addr(input logic [1:0] w, input logic [AW-1:0] a, input int g);
    logic [1:0] gg = 2'(g);
    if (w == 2'd0) return {a, gg};
    if (w == 2'd1) return {1'b0, a, gg[0]};
    return {2'b00, a};
  endfunction

  // Enabled lanes of cpu_data must carry the narrow data.
  function automatic logic [31:0] lanes_of(input logic [1:0] w, input logic [31:0] bus, input int g);
    if (w == 2'd0) return {24'h0, bus[8*g +: 8]};
    if (w == 2'd1) return {16'h0, bus[16*g +: 16]};
    return bus;
  endfunction

  function automatic logic [31:0] narrow_of(input logic [1:0] w, input logic [31:0] d);
    if (w == 2'd0) return {24'h0, d[7:0]};
    if (w == 2'd1) return {16'h0, d[15:0]};
    return d;
  endfunction

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check("R1 wait_n in reset", wait_n, 1);
    check("R1 lane_en in reset", lane_en, 4'hF);
    rst = 1'b0;
    @(negedge clk); #1;
    check("R1 wait_n idle", wait_n, 1);
    check("R1 lane_en idle", lane_en, 4'hF);
  endtask

  // Read with `stalls` not-ready cycles in front of every group.
  // When conflict is set, a new request arrives during the access.
  task automatic t_read(input string tag, input logic [1:0] w, input logic [AW-1:0] a,
                        input int stalls, input bit conflict);
    logic [1:0] we;
    int ng;
    we = (w == 2'd3) ? 2'd2 : w;
    ng = n_groups(we);
    @(negedge clk);
    req = 1'b1; wr = 1'b0; width_sel = w; word_addr = a; mem_rdy = 1'b0;
    @(negedge clk);
    req = 1'b0;
    for (int g = 0; g < ng; g++) begin
      logic [31:0] d;
      d = 32'hC3A50000 ^ (32'h01020304 * (g + 1)) ^ {22'h0, a};
      mem_rdata = d;
      for (int s = 0; s < stalls; s++) begin
        mem_rdy = 1'b0;
        if (conflict) begin
          req = 1'b1; width_sel = 2'd0; word_addr = ~a; wr = 1'b1;
        end
        #1;
        check({tag, " R6 stall lane_en"}, lane_en, exp_en(we, g));
        check({tag, " R6 stall addr"}, mem_addr, exp_addr(we, a, g));
        check({tag, " R5 stall wait_n"}, wait_n, 0);
        @(negedge clk);
      end
      mem_rdy = 1'b1;
      #1;
      check({tag, " lane_en"}, lane_en, exp_en(we, g));
      check({tag, " R7 addr"}, mem_addr, exp_addr(we, a, g));
      check({tag, " data"}, lanes_of(we, cpu_data, g), narrow_of(we, d));
      check({tag, " R5 wait_n"}, wait_n, (g == ng - 1) ? 1 : 0);
      @(negedge clk);
    end
    req = 1'b0; wr = 1'b0; mem_rdy = 1'b0;
    #1;
    check({tag, " R5 idle after"}, wait_n, 1);
    check({tag, " R1 lane_en after"}, lane_en, 4'hF);
  endtask

  task automatic t_store(input logic [1:0] w, input logic [AW-1:0] a);
    logic [1:0] we;
    we = (w == 2'd3) ? 2'd2 : w;
    @(negedge clk);
    req = 1'b1; wr = 1'b1; width_sel = w; word_addr = a; mem_rdy = 1'b0;
    @(negedge clk);
    req = 1'b0; wr = 1'b0;
    #1;
    check("R8 store stall wait_n", wait_n, 0);
    check("R8 store lane_en", lane_en, 4'hF);
    @(negedge clk);
    mem_rdy = 1'b1;
    #1;
    check("R8 store lane_en ready", lane_en, 4'hF);
    check("R8 store addr", mem_addr, exp_addr(we, a, 0));
    check("R8 store single pass", wait_n, 1);
    @(negedge clk);
    mem_rdy = 1'b0;
    #1;
    check("R8 store done", wait_n, 1);
  endtask

  initial begin
    t_reset();
    t_read("R2 word", 2'd2, 10'h155, 0, 1'b0);
    t_read("R2 word stall", 2'd2, 10'h2AA, 2, 1'b0);
    t_read("R3 half", 2'd1, 10'h0F3, 0, 1'b0);
    t_read("R3 half stall", 2'd1, 10'h3C0, 3, 1'b0);
    t_read("R4 byte", 2'd0, 10'h1E7, 0, 1'b0);
    t_read("R4 byte stall", 2'd0, 10'h001, 2, 1'b0);
    t_read("R9 half conflict", 2'd1, 10'h246, 2, 1'b1);
    t_read("R9 byte conflict", 2'd0, 10'h3FF, 1, 1'b1);
    t_read("R10 code3", 2'd3, 10'h0AB, 1, 1'b0);
    t_store(2'd0, 10'h111);
    t_store(2'd1, 10'h222);
    t_store(2'd2, 10'h333);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule